// File: doc/BRIEF.md
# ADC calibration and enable controller

This block sits between a bus-side register file and an analog-to-digital converter core. It sequences the core's lifecycle. Software starts a calibration, waits until it finishes, powers the converter up and then waits for a ready indication. After that, the block records each conversion result the core delivers. The analog core itself is not modelled. A one-cycle result-valid pulse stands in for the core's conversion output. Internal counters stand in for the calibration duration and for the converter startup time.

Three small bus registers are used:

- **Command register** (select 0). It starts calibration, enables the converter and disables it.
- **Status register** (select 1). It reports readiness, the end-of-conversion flag and the overrun flag. A write of 1 to a flag bit clears that flag.
- **Result register** (select 2). It returns the newest result. Reading it also acknowledges end-of-conversion.

The design is built to stay correct in sequencing corner cases:

- a calibration requested on the very first cycle after the previous one ends;
- an enable issued immediately after calibration;
- a flag clear that lands in the same cycle as a fresh result.

Top module: `adcc_ctrl`

## Requirements
- R1: A write of 1 to command bit 0 (calibrate) is ignored while the converter is enabled. Calibration busy stays 0.
- R2: An accepted calibrate write raises calibration busy on the next cycle. Busy stays 1 for exactly CAL_LEN (default 16) cycles and then clears without software action.
- R3: A calibrate write issued on the first cycle after busy has cleared starts a new calibration normally. That calibration also clears after CAL_LEN cycles and never remains stuck at 1.
- R4: A write of 1 to command bit 1 (enable) sets the converter enable on the next cycle when calibration is idle. This includes the first cycle after a calibration ends. The enable is ignored while calibration is busy, and also when the same write requests a calibration. A write of 1 to command bit 2 (disable) clears both enable and ready on the next cycle, and takes priority over enable.
- R5: Ready (status bit 0) rises START_LEN (default 4) cycles after enable rises. Ready is never 1 while enable is 0.
- R6: A result-valid pulse while ready sets end-of-conversion (status bit 1). Two actions clear it: a read of select 2, or a write of 1 to status bit 1. Result pulses while not ready are ignored.
- R7: A result accepted while end-of-conversion is already 1 sets overrun (status bit 2). This also applies when a clear of end-of-conversion lands in the same cycle. In that case end-of-conversion stays 1.
- R8: The result register always holds the newest accepted result, including on overrun. A write of 1 to status bit 2 clears overrun, but a coinciding new overrun wins.
- R9: Read data is combinational on the select. Select 0 returns {enable, busy} in bits 1:0, select 1 returns {overrun, eoc, ready} in bits 2:0, select 2 returns the result zero-extended, and select 3 returns 0.
- R10: During reset, busy, enable, ready, end-of-conversion and overrun are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect on select 2) |
| addr | input | 2 | Register select |
| wdata | input | BUS_W | Write data |
| rdata | output | BUS_W | Read data, combinational on addr |
| res_valid | input | 1 | One-cycle pulse: core has a new result |
| res_data | input | DW | Result value from the core |
| cal_busy_o | output | 1 | Calibration in progress |
| conv_en_o | output | 1 | Converter enabled |
| conv_rdy_o | output | 1 | Converter ready |
| eoc_o | output | 1 | End-of-conversion flag |
| ovr_o | output | 1 | Overrun flag |

## Verification
Every flag and control bit is registered once, so its response to a write or a result pulse appears one clock after the edge that samples the stimulus. The two exceptions are the longer delays: calibration busy falls CAL_LEN edges after it rose, and ready rises START_LEN edges after enable rose. Read data is combinational and is compared just after the inputs are driven, before the next edge. The bench drives inputs on the falling edge and advances its own cycle model on the rising edge. It compares every output one time unit after that edge, so each check lands exactly in the cycle where the result is due.

// File: rtl/adcc_pkg.sv
`timescale 1ns/1ps
package adcc_pkg;
    typedef enum logic [1:0] {
        SEL_CMD  = 2'd0,
        SEL_STAT = 2'd1,
        SEL_RES  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam int CMD_CAL_BIT  = 0;
    localparam int CMD_EN_BIT   = 1;
    localparam int CMD_DIS_BIT  = 2;

    localparam int STAT_RDY_BIT = 0;
    localparam int STAT_EOC_BIT = 1;
    localparam int STAT_OVR_BIT = 2;
endpackage

// File: rtl/adcc_cal_seq.sv
`timescale 1ns/1ps
module adcc_cal_seq #(
    parameter int CAL_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_wr,
    input  logic conv_en,
    output logic busy_o
);
    localparam int CW = $clog2(CAL_LEN + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } cal_st_t;

    cal_st_t s_d, s_q;

    // Busy is cleared only by its own counter. No other path can set it again,
    // so back-to-back runs start from a clean state.
    always_comb begin
        s_d = s_q;
        if (s_q.busy) begin
            if (s_q.cnt == '0) begin
                s_d.busy = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt - CW'(1);
            end
        end else if (start_wr && !conv_en) begin
            s_d.busy = 1'b1;
            s_d.cnt  = CW'(CAL_LEN - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o = s_q.busy;
endmodule

// File: rtl/adcc_pwr.sv
`timescale 1ns/1ps
module adcc_pwr #(
    parameter int START_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_wr,
    input  logic dis_wr,
    input  logic cal_start_wr,
    input  logic cal_busy,
    output logic en_o,
    output logic rdy_o
);
    localparam int SW = $clog2(START_LEN + 1);

    typedef struct packed {
        logic          en;
        logic          rdy;
        logic [SW-1:0] cnt;
    } pwr_st_t;

    pwr_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (dis_wr) begin
            s_d.en  = 1'b0;
            s_d.rdy = 1'b0;
            s_d.cnt = '0;
        end else if (!s_q.en) begin
            if (en_wr && !cal_busy && !cal_start_wr) begin
                s_d.en  = 1'b1;
                s_d.cnt = SW'(START_LEN - 1);
            end
        end else if (!s_q.rdy) begin
            if (s_q.cnt == '0) begin
                s_d.rdy = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - SW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign en_o  = s_q.en;
    assign rdy_o = s_q.rdy;
endmodule

// File: rtl/adcc_flags.sv
`timescale 1ns/1ps
module adcc_flags #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          res_valid,
    input  logic [DW-1:0] res_data,
    input  logic          rdy,
    input  logic          eoc_clr,
    input  logic          ovr_clr,
    output logic          eoc_o,
    output logic          ovr_o,
    output logic [DW-1:0] data_o
);
    typedef struct packed {
        logic          eoc;
        logic          ovr;
        logic [DW-1:0] data;
    } flg_st_t;

    flg_st_t s_d, s_q;
    logic    take;

    assign take = res_valid && rdy;

    // Overrun is judged on the registered flag, not on the flag after the
    // clear. A clear in the same cycle therefore cannot hide the overrun.
    always_comb begin
        s_d = s_q;
        if (eoc_clr) s_d.eoc = 1'b0;
        if (ovr_clr) s_d.ovr = 1'b0;
        if (take) begin
            s_d.data = res_data;
            s_d.eoc  = 1'b1;
            if (s_q.eoc) s_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign eoc_o  = s_q.eoc;
    assign ovr_o  = s_q.ovr;
    assign data_o = s_q.data;
endmodule

// File: rtl/adcc_ctrl.sv
`timescale 1ns/1ps
module adcc_ctrl
    import adcc_pkg::*;
#(
    parameter int BUS_W     = 16,
    parameter int DW        = 12,
    parameter int CAL_LEN   = 16,
    parameter int START_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       addr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    input  logic             res_valid,
    input  logic [DW-1:0]    res_data,
    output logic             cal_busy_o,
    output logic             conv_en_o,
    output logic             conv_rdy_o,
    output logic             eoc_o,
    output logic             ovr_o
);
    reg_sel_e      sel;
    logic          wr_cmd, wr_stat;
    logic          cal_start_wr, en_wr, dis_wr;
    logic          eoc_clr, ovr_clr;
    logic [DW-1:0] res_q;

    assign sel          = reg_sel_e'(addr);
    assign wr_cmd       = wr_en && (sel == SEL_CMD);
    assign wr_stat      = wr_en && (sel == SEL_STAT);
    assign cal_start_wr = wr_cmd && wdata[CMD_CAL_BIT];
    assign en_wr        = wr_cmd && wdata[CMD_EN_BIT];
    assign dis_wr       = wr_cmd && wdata[CMD_DIS_BIT];
    assign eoc_clr      = (rd_en && (sel == SEL_RES)) || (wr_stat && wdata[STAT_EOC_BIT]);
    assign ovr_clr      = wr_stat && wdata[STAT_OVR_BIT];

    adcc_cal_seq #(.CAL_LEN(CAL_LEN)) u_cal (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_wr (cal_start_wr),
        .conv_en  (conv_en_o),
        .busy_o   (cal_busy_o)
    );

    adcc_pwr #(.START_LEN(START_LEN)) u_pwr (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_wr        (en_wr),
        .dis_wr       (dis_wr),
        .cal_start_wr (cal_start_wr),
        .cal_busy     (cal_busy_o),
        .en_o         (conv_en_o),
        .rdy_o        (conv_rdy_o)
    );

    adcc_flags #(.DW(DW)) u_flg (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_valid (res_valid),
        .res_data  (res_data),
        .rdy       (conv_rdy_o),
        .eoc_clr   (eoc_clr),
        .ovr_clr   (ovr_clr),
        .eoc_o     (eoc_o),
        .ovr_o     (ovr_o),
        .data_o    (res_q)
    );

    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_CMD: begin
                rdata[CMD_CAL_BIT] = cal_busy_o;
                rdata[CMD_EN_BIT]  = conv_en_o;
            end
            SEL_STAT: begin
                rdata[STAT_RDY_BIT] = conv_rdy_o;
                rdata[STAT_EOC_BIT] = eoc_o;
                rdata[STAT_OVR_BIT] = ovr_o;
            end
            SEL_RES:  rdata = BUS_W'(res_q);
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/adcc_ctrl_chk.sv
`timescale 1ns/1ps
module adcc_ctrl_chk #(
    parameter int BUS_W   = 16,
    parameter int CAL_LEN = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic [1:0]       addr,
    input logic [BUS_W-1:0] wdata,
    input logic             res_valid,
    input logic             cal_busy_o,
    input logic             conv_en_o,
    input logic             conv_rdy_o,
    input logic             eoc_o,
    input logic             ovr_o
);
    localparam int RW = $clog2(CAL_LEN + 2);
    logic [RW-1:0] busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_run <= '0;
        end else if (cal_busy_o) begin
            busy_run <= busy_run + RW'(1);
        end else begin
            busy_run <= '0;
        end
    end

    logic cmd_wr;
    assign cmd_wr = wr_en && (addr == 2'd0);

    p_start_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_en_o && cmd_wr && wdata[0]) |=> !cal_busy_o);

    p_cal_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cal_busy_o) |-> (busy_run == RW'(CAL_LEN)));

    p_cal_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= RW'(CAL_LEN));

    p_cal_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cal_busy_o && !conv_en_o && cmd_wr && wdata[0]) |=> cal_busy_o);

    p_en_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cal_busy_o && cmd_wr && wdata[1] && !wdata[0] && !wdata[2]) |=> conv_en_o);

    p_cal_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cal_busy_o |-> !conv_en_o);

    p_rdy_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_rdy_o |-> conv_en_o);

    p_eoc_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc_o && rd_en && addr == 2'd2 && !res_valid) |=> !eoc_o);

    p_ovr_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc_o && res_valid && conv_rdy_o) |=> (ovr_o && eoc_o));
endmodule

bind adcc_ctrl adcc_ctrl_chk #(.BUS_W(BUS_W), .CAL_LEN(CAL_LEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .res_valid  (res_valid),
    .cal_busy_o (cal_busy_o),
    .conv_en_o  (conv_en_o),
    .conv_rdy_o (conv_rdy_o),
    .eoc_o      (eoc_o),
    .ovr_o      (ovr_o)
);

// File: tb/tb_adcc_ctrl.sv
`timescale 1ns/1ps
module tb_adcc_ctrl;
    localparam int BUS_W     = 16;
    localparam int DW        = 12;
    localparam int CAL_LEN   = 16;
    localparam int START_LEN = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0, rd_en = 1'b0, res_valid = 1'b0;
    logic [1:0]       addr = '0;
    logic [BUS_W-1:0] wdata = '0;
    logic [DW-1:0]    res_data = '0;
    logic [BUS_W-1:0] rdata;
    logic             cal_busy_o, conv_en_o, conv_rdy_o, eoc_o, ovr_o;

    adcc_ctrl #(.BUS_W(BUS_W), .DW(DW), .CAL_LEN(CAL_LEN), .START_LEN(START_LEN)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .res_valid(res_valid), .res_data(res_data),
        .cal_busy_o(cal_busy_o), .conv_en_o(conv_en_o), .conv_rdy_o(conv_rdy_o),
        .eoc_o(eoc_o), .ovr_o(ovr_o)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    logic finished = 1'b0;

    // Cycle model built from the requirements.
    logic          m_cal = 1'b0, m_en = 1'b0, m_rdy = 1'b0, m_eoc = 1'b0, m_ovr = 1'b0;
    int            m_ccnt = 0, m_scnt = 0;
    logic [DW-1:0] m_data = '0;
    logic [BUS_W-1:0] last_rdata;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [BUS_W-1:0] exp_rdata(input logic [1:0] a);
        logic [BUS_W-1:0] r = '0;
        case (a)
            2'd0: begin r[0] = m_cal; r[1] = m_en; end
            2'd1: begin r[0] = m_rdy; r[1] = m_eoc; r[2] = m_ovr; end
            2'd2: r = BUS_W'(m_data);
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic step(input logic w, input logic r, input logic [1:0] a,
                        input logic [BUS_W-1:0] wd, input logic rv, input logic [DW-1:0] rd);
        logic          n_cal, n_en, n_rdy, n_eoc, n_ovr;
        int            n_ccnt, n_scnt;
        logic [DW-1:0] n_data;
        logic          start, enw, disw, eclr, oclr, take;
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = wd; res_valid = rv; res_data = rd;
        #1;
        last_rdata = rdata;
        check("R9 read data", 32'(rdata), 32'(exp_rdata(a)));
        start = w && a == 2'd0 && wd[0];
        enw   = w && a == 2'd0 && wd[1];
        disw  = w && a == 2'd0 && wd[2];
        eclr  = (r && a == 2'd2) || (w && a == 2'd1 && wd[1]);
        oclr  = w && a == 2'd1 && wd[2];
        take  = rv && m_rdy;
        n_cal = m_cal; n_ccnt = m_ccnt;
        if (m_cal) begin
            if (m_ccnt == 0) n_cal = 1'b0; else n_ccnt = m_ccnt - 1;
        end else if (start && !m_en) begin
            n_cal = 1'b1; n_ccnt = CAL_LEN - 1;
        end
        n_en = m_en; n_rdy = m_rdy; n_scnt = m_scnt;
        if (disw) begin
            n_en = 1'b0; n_rdy = 1'b0; n_scnt = 0;
        end else if (!m_en) begin
            if (enw && !m_cal && !start) begin n_en = 1'b1; n_scnt = START_LEN - 1; end
        end else if (!m_rdy) begin
            if (m_scnt == 0) n_rdy = 1'b1; else n_scnt = m_scnt - 1;
        end
        n_eoc = m_eoc; n_ovr = m_ovr; n_data = m_data;
        if (eclr) n_eoc = 1'b0;
        if (oclr) n_ovr = 1'b0;
        if (take) begin
            n_data = rd; n_eoc = 1'b1;
            if (m_eoc) n_ovr = 1'b1;
        end
        @(posedge clk);
        #1;
        m_cal = n_cal; m_ccnt = n_ccnt; m_en = n_en; m_rdy = n_rdy; m_scnt = n_scnt;
        m_eoc = n_eoc; m_ovr = n_ovr; m_data = n_data;
        check("R2 cal busy", 32'(cal_busy_o), 32'(m_cal));
        check("R4 enable",   32'(conv_en_o),  32'(m_en));
        check("R5 ready",    32'(conv_rdy_o), 32'(m_rdy));
        check("R6 eoc",      32'(eoc_o),      32'(m_eoc));
        check("R7 overrun",  32'(ovr_o),      32'(m_ovr));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 2'd0, '0, 1'b0, '0);
    endtask

    initial begin
        #2000000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        check("R10 busy",  32'(cal_busy_o), 0);
        check("R10 en",    32'(conv_en_o), 0);
        check("R10 rdy",   32'(conv_rdy_o), 0);
        check("R10 eoc",   32'(eoc_o), 0);
        check("R10 ovr",   32'(ovr_o), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: calibration length
        step(1, 0, 2'd0, 16'h1, 0, '0);
        check("R2 busy after start", 32'(cal_busy_o), 1);
        idle(CAL_LEN - 1);
        check("R2 busy before end", 32'(cal_busy_o), 1);
        idle(1);
        check("R2 busy cleared", 32'(cal_busy_o), 0);
        // R3: back-to-back calibration
        step(1, 0, 2'd0, 16'h1, 0, '0);
        check("R3 second start", 32'(cal_busy_o), 1);
        // R4: enable during calibration ignored
        step(1, 0, 2'd0, 16'h2, 0, '0);
        check("R4 enable ignored while busy", 32'(conv_en_o), 0);
        idle(CAL_LEN - 1);
        check("R3 second cal cleared", 32'(cal_busy_o), 0);
        // R4: enable on first cycle after calibration
        step(1, 0, 2'd0, 16'h2, 0, '0);
        check("R4 enable right after cal", 32'(conv_en_o), 1);
        idle(START_LEN - 1);
        check("R5 not yet ready", 32'(conv_rdy_o), 0);
        idle(1);
        check("R5 ready after startup", 32'(conv_rdy_o), 1);
        // R1: calibrate while enabled
        step(1, 0, 2'd0, 16'h1, 0, '0);
        check("R1 start ignored while enabled", 32'(cal_busy_o), 0);
        // R6: result and data read
        step(0, 0, 2'd0, '0, 1, 12'hABC);
        check("R6 eoc set", 32'(eoc_o), 1);
        step(0, 1, 2'd2, '0, 0, '0);
        check("R8 data value", 32'(last_rdata), 32'h0ABC);
        check("R6 eoc cleared by read", 32'(eoc_o), 0);
        // R7: coincident clear and new result
        step(0, 0, 2'd0, '0, 1, 12'h123);
        step(0, 1, 2'd2, '0, 1, 12'h456);
        check("R7 eoc kept", 32'(eoc_o), 1);
        check("R7 overrun on coincident clear", 32'(ovr_o), 1);
        // R8: overrun set wins over clear, newest data kept
        step(1, 0, 2'd1, 16'h4, 1, 12'h789);
        check("R8 overrun set wins", 32'(ovr_o), 1);
        step(0, 1, 2'd2, '0, 0, '0);
        check("R8 newest data", 32'(last_rdata), 32'h0789);
        step(1, 0, 2'd1, 16'h4, 0, '0);
        check("R8 overrun cleared", 32'(ovr_o), 0);
        // R6: write-1 clear of eoc
        step(0, 0, 2'd0, '0, 1, 12'h055);
        step(1, 0, 2'd1, 16'h2, 0, '0);
        check("R6 eoc cleared by write", 32'(eoc_o), 0);
        // R4: disable, R6: results ignored while not ready
        step(1, 0, 2'd0, 16'h4, 0, '0);
        check("R4 disable en", 32'(conv_en_o), 0);
        check("R4 disable rdy", 32'(conv_rdy_o), 0);
        step(0, 0, 2'd0, '0, 1, 12'hFFF);
        check("R6 result ignored when not ready", 32'(eoc_o), 0);
        step(0, 0, 2'd2, '0, 0, '0);
        check("R6 data unchanged when not ready", 32'(last_rdata), 32'h0055);

        // Random phase with fixed seed
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4000; i++) begin
            logic [BUS_W-1:0] wd;
            wd = '0;
            wd[0] = ($urandom % 3) == 0;
            wd[1] = ($urandom % 2) == 0;
            wd[2] = ($urandom % 10) == 0;
            step(($urandom % 3) == 0, ($urandom % 3) == 0, 2'($urandom % 4),
                 wd, ($urandom % 3) == 0, DW'($urandom));
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule